// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo serial audio stream into parallel samples. It runs on the link's bit clock and samples the frame clock and the serial data on each rising edge. A change in the frame clock marks the start of a channel half. Within each half the block collects the data bits that the selected format defines. When the right word of a frame is complete, the block presents the left and right samples together and raises a one-cycle strobe.

Five formats are supported. Three are LSB-justified, carrying 16-, 20- or 24-bit words whose last bit lands in the final bit period of the half. The other two carry 24-bit words that start at the frame-clock change: one with the first word bit in the first period of the half (MSB-justified), one with the first word bit one period later (I2S). Shorter words are placed at the top of the 24-bit output and their low bits are filled with zeros, so that full scale is the same in every format. In the justified formats a high frame clock marks the left channel. In I2S a low frame clock marks the left channel.

Top module: `audio_rx`

## Requirements
- R1: With fmt = 3'b000, the last 16 bits of each half form the word, MSB first, and the output is that word in bits 23:8 with bits 7:0 zero.
- R2: With fmt = 3'b001, the last 20 bits of each half form the word, and the output is that word in bits 23:4 with bits 3:0 zero.
- R3: With fmt = 3'b100, the last 24 bits of each half form the 24-bit output word.
- R4: With fmt = 3'b010 (the value for a plain MSB-justified source), the 24 bits sampled from the first bit period of the half onward form the word, and any later bits in the half are ignored.
- R5: With fmt = 3'b011 (I2S), the word starts one bit period after the frame-clock change, and a low frame clock marks the left channel.
- R6: In the three LSB-justified formats and the MSB-justified format, the half with the frame clock high is the left channel and the half with it low is the right channel.
- R7: `valid` is high for exactly one bit-clock cycle per frame. It rises in the cycle after the rising edge that first samples the frame clock at the left level following a right half. `left_out` and `right_out` carry that frame's pair while `valid` is high.
- R8: After reset, `left_out` and `right_out` are zero and `valid` is low. No pair is presented until one complete left half and then one complete right half have been received, so a lone right half after reset produces no strobe.
- R9: In the LSB-justified formats, bits that come before the word in a half have no effect on the output.
- R10: `left_out` and `right_out` keep their values between strobes.
- R11: Halves of any length at least as long as the word are accepted. This is 24 bit periods for the MSB-justified format and 25 for I2S; halves longer than the counter range also work.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 3 | Format select (encodings in R1 to R5) |
| frame_clk | input | 1 | Frame/word clock that selects the channel |
| ser_data | input | 1 | Serial data, MSB first, two's complement |
| left_out | output | 24 | Left sample of the most recent frame |
| right_out | output | 24 | Right sample of the most recent frame |
| valid | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
The bench builds the block with its default values: 24-bit samples and a 6-bit position counter that stops at 63. With these values, 32-period halves test the normal stereo case. Halves of 24 periods (and 25 periods for I2S) put the word window exactly at the edges of the half. Don't-care bits are driven high, so any stray bit shifted into the word shows up in the output.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int SAMPLE_W = 24;

    typedef enum logic [2:0] {
        FMT_LSB16 = 3'b000,
        FMT_LSB20 = 3'b001,
        FMT_MSB24 = 3'b010,
        FMT_I2S24 = 3'b011,
        FMT_LSB24 = 3'b100
    } fmt_e;

    // Decoded view of a format select.
    typedef struct packed {
        logic       lsb_just;  // word ends at the half's last bit
        logic       left_low;  // low frame level means left channel
        logic [1:0] lead;      // bit periods between level change and MSB
        logic [4:0] width;     // word length in bits
    } fmt_cfg_t;

    function automatic fmt_cfg_t decode_fmt(input logic [2:0] sel);
        fmt_cfg_t c;
        c.lsb_just = 1'b0;
        c.left_low = 1'b0;
        c.lead     = 2'd0;
        c.width    = 5'd24;
        case (sel)
            FMT_LSB16: begin c.lsb_just = 1'b1; c.width = 5'd16; end
            FMT_LSB20: begin c.lsb_just = 1'b1; c.width = 5'd20; end
            FMT_LSB24: begin c.lsb_just = 1'b1; end
            FMT_I2S24: begin c.left_low = 1'b1; c.lead = 2'd1; end
            default:   ;
        endcase
        return c;
    endfunction

    // Place a short word at the top of the sample, zero-filling below.
    function automatic logic [SAMPLE_W-1:0] align_word(input logic [SAMPLE_W-1:0] raw,
                                                       input logic [4:0] width);
        case (width)
            5'd16:   return {raw[15:0], 8'h00};
            5'd20:   return {raw[19:0], 4'h0};
            default: return raw;
        endcase
    endfunction

endpackage

// File: rtl/arx_framer.sv
module arx_framer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_lvl,
    output logic             lvl_change,
    output logic             half_end,
    output logic             prev_lvl,
    output logic             started,
    output logic [CNT_W-1:0] bit_idx
);
    localparam logic [CNT_W-1:0] POS_MAX = '1;

    logic             lvl_q;
    logic             run_q;
    logic [CNT_W-1:0] pos_q;

    assign lvl_change = (frame_lvl != lvl_q);
    assign half_end   = lvl_change && run_q;
    assign prev_lvl   = lvl_q;
    assign started    = run_q;
    assign bit_idx    = lvl_change ? '0 : pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            run_q <= 1'b0;
            pos_q <= '0;
        end else begin
            lvl_q <= frame_lvl;
            if (lvl_change) begin
                run_q <= 1'b1;
                pos_q <= CNT_W'(1);
            end else if (pos_q != POS_MAX) begin
                pos_q <= pos_q + CNT_W'(1);
            end
        end
    end

    // R8: once a frame boundary has been seen, tracking stays active
    a_r8_started_sticky: assert property (@(posedge clk) disable iff (rst)
        started |=> started);

endmodule

// File: rtl/arx_shifter.sv
module arx_shifter
    import arx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_bit,
    input  logic                lvl_change,
    input  logic [CNT_W-1:0]    bit_idx,
    input  logic                lsb_just,
    input  logic [1:0]          lead,
    input  logic [4:0]          width,
    output logic [SAMPLE_W-1:0] word
);
    localparam int IDX_W = CNT_W + 1;

    logic [SAMPLE_W-1:0] sh_q;
    logic [IDX_W-1:0]    idx_x;
    logic [IDX_W-1:0]    lead_x;
    logic                in_window;

    assign idx_x     = IDX_W'(bit_idx);
    assign lead_x    = IDX_W'(lead);
    assign in_window = lsb_just ||
                       ((idx_x >= lead_x) && (idx_x < lead_x + IDX_W'(SAMPLE_W)));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (lvl_change) begin
            sh_q <= in_window ? SAMPLE_W'(ser_bit) : '0;
        end else if (in_window) begin
            sh_q <= {sh_q[SAMPLE_W-2:0], ser_bit};
        end
    end

    assign word = align_word(sh_q, width);

    // R1 R2: short words always leave the low bits of the sample clear
    a_r1_short_low_zero: assert property (@(posedge clk) disable iff (rst)
        (width == 5'd16) |-> (word[7:0] == 8'h00));

endmodule

// File: rtl/arx_pair.sv
module arx_pair
    import arx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                half_end,
    input  logic                end_left,
    input  logic                started,
    input  logic [SAMPLE_W-1:0] word,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                valid
);
    logic [SAMPLE_W-1:0] stage_l;
    logic                have_left;
    logic                armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_l   <= '0;
            have_left <= 1'b0;
            left_out  <= '0;
            right_out <= '0;
            valid     <= 1'b0;
            armed_q   <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            valid   <= 1'b0;
            if (half_end) begin
                if (end_left) begin
                    stage_l   <= word;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_out  <= stage_l;
                    right_out <= word;
                    valid     <= 1'b1;
                    have_left <= 1'b0;
                end
            end
        end
    end

    // R7: strobe lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R7: strobe only follows a completed half
    a_r7_after_half_end: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(half_end));

    // R8: no pair before frame tracking has started
    a_r8_valid_needs_start: assert property (@(posedge clk) disable iff (rst)
        valid |-> started);

    // R10: outputs hold between strobes
    a_r10_hold: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !valid |-> ($stable(left_out) && $stable(right_out)));

endmodule

// File: rtl/audio_rx.sv
module audio_rx
    import arx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                bit_clk,
    input  logic                rst,
    input  logic [2:0]          fmt,
    input  logic                frame_clk,
    input  logic                ser_data,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                valid
);
    fmt_cfg_t            cfg;
    logic                lvl_change;
    logic                half_end;
    logic                prev_lvl;
    logic                started;
    logic [CNT_W-1:0]    bit_idx;
    logic [SAMPLE_W-1:0] word;
    logic                end_left;

    assign cfg      = decode_fmt(fmt);
    assign end_left = (prev_lvl == !cfg.left_low);

    arx_framer #(.CNT_W(CNT_W)) u_framer (
        .clk        (bit_clk),
        .rst        (rst),
        .frame_lvl  (frame_clk),
        .lvl_change (lvl_change),
        .half_end   (half_end),
        .prev_lvl   (prev_lvl),
        .started    (started),
        .bit_idx    (bit_idx)
    );

    arx_shifter #(.CNT_W(CNT_W)) u_shifter (
        .clk        (bit_clk),
        .rst        (rst),
        .ser_bit    (ser_data),
        .lvl_change (lvl_change),
        .bit_idx    (bit_idx),
        .lsb_just   (cfg.lsb_just),
        .lead       (cfg.lead),
        .width      (cfg.width),
        .word       (word)
    );

    arx_pair u_pair (
        .clk       (bit_clk),
        .rst       (rst),
        .half_end  (half_end),
        .end_left  (end_left),
        .started   (started),
        .word      (word),
        .left_out  (left_out),
        .right_out (right_out),
        .valid     (valid)
    );

endmodule

// File: tb/audio_rx_bench.sv
module audio_rx_bench;
    localparam int CLK_PERIOD = 10;

    logic        bit_clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fmt = 3'b010;
    logic        frame_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic [23:0] left_out, right_out;
    logic        valid;

    int tests = 0;
    int fails = 0;
    int n_cap = 0;
    logic [23:0] cap_l [0:63];
    logic [23:0] cap_r [0:63];

    audio_rx u_audio_rx (
        .bit_clk   (bit_clk),
        .rst       (rst),
        .fmt       (fmt),
        .frame_clk (frame_clk),
        .ser_data  (ser_data),
        .left_out  (left_out),
        .right_out (right_out),
        .valid     (valid)
    );

    always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

    always @(negedge bit_clk) begin
        if (!rst && valid) begin
            if (n_cap < 64) begin
                cap_l[n_cap] = left_out;
                cap_r[n_cap] = right_out;
            end
            n_cap = n_cap + 1;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [47:0] act, input logic [47:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // style: 0 LSB-justified, 1 MSB-justified, 2 I2S
    task automatic start(input logic [2:0] f, input int style);
        @(negedge bit_clk);
        rst = 1'b1;
        fmt = f;
        frame_clk = (style == 2);
        ser_data = 1'b0;
        repeat (3) @(negedge bit_clk);
        rst = 1'b0;
        repeat (2) @(negedge bit_clk);
    endtask

    task automatic send_half(input bit lvl, input logic [23:0] w, input int n,
                             input int bph, input int style);
        for (int i = 0; i < bph; i++) begin
            int k;
            @(negedge bit_clk);
            frame_clk = lvl;
            if (style == 0) k = i - (bph - n);
            else            k = i - ((style == 2) ? 1 : 0);
            if (k >= 0 && k < n) ser_data = w[n-1-k];
            else                 ser_data = 1'b1;
        end
    endtask

    task automatic send_frame(input int style, input logic [23:0] l, input logic [23:0] r,
                              input int n, input int bph);
        bit left_lvl;
        left_lvl = (style != 2);
        send_half(left_lvl, l, n, bph, style);
        send_half(!left_lvl, r, n, bph, style);
    endtask

    // R7: start the next frame and watch the strobe cycle by cycle
    task automatic finish_frame(input int style);
        @(negedge bit_clk);
        frame_clk = (style != 2);
        ser_data = 1'b0;
        @(negedge bit_clk);
        check(valid === 1'b1, "R7 strobe after next frame edge", 48'(valid), 48'd1);
        @(negedge bit_clk);
        check(valid === 1'b0, "R7 strobe one cycle", 48'(valid), 48'd0);
        #1;
    endtask

    task automatic check_pair(input int idx, input logic [23:0] el, input logic [23:0] er,
                              input string tag);
        check({cap_l[idx], cap_r[idx]} === {el, er}, tag,
              {cap_l[idx], cap_r[idx]}, {el, er});
    endtask

    task automatic test_reset;
        start(3'b010, 1);
        check({left_out, right_out} === 48'd0, "R8 reset outputs", {left_out, right_out}, 48'd0);
        check(valid === 1'b0, "R8 reset strobe", 48'(valid), 48'd0);
    endtask

    task automatic test_lsb16;
        int base;
        start(3'b000, 0);
        base = n_cap;
        send_frame(0, 24'h8001, 24'h7FFE, 16, 32);
        send_frame(0, 24'h00FF, 24'hFF00, 16, 32);
        finish_frame(0);
        check(n_cap - base == 2, "R7 pair count lsb16", 48'(n_cap - base), 48'd2);
        check_pair(base,     24'h800100, 24'h7FFE00, "R1 R9 lsb16 frame0");
        check_pair(base + 1, 24'h00FF00, 24'hFF0000, "R1 R9 lsb16 frame1");
    endtask

    task automatic test_lsb20;
        int base;
        start(3'b001, 0);
        base = n_cap;
        send_frame(0, 24'h80001, 24'h7FFFE, 20, 32);
        send_frame(0, 24'h12345, 24'hABCDE, 20, 32);
        finish_frame(0);
        check(n_cap - base == 2, "R7 pair count lsb20", 48'(n_cap - base), 48'd2);
        check_pair(base,     24'h800010, 24'h7FFFE0, "R2 R9 lsb20 frame0");
        check_pair(base + 1, 24'h123450, 24'hABCDE0, "R2 R9 lsb20 frame1");
    endtask

    task automatic test_lsb24;
        int base;
        start(3'b100, 0);
        base = n_cap;
        send_frame(0, 24'h800001, 24'h7FFFFE, 24, 32);
        send_frame(0, 24'h123456, 24'hFEDCBA, 24, 24);
        finish_frame(0);
        check(n_cap - base == 2, "R7 pair count lsb24", 48'(n_cap - base), 48'd2);
        check_pair(base,     24'h800001, 24'h7FFFFE, "R3 lsb24 32-bit half");
        check_pair(base + 1, 24'h123456, 24'hFEDCBA, "R3 R11 lsb24 24-bit half");
    endtask

    task automatic test_msb;
        int base;
        start(3'b010, 1);
        base = n_cap;
        send_frame(1, 24'hA5A5A4, 24'h5A5A5A, 24, 32);
        send_frame(1, 24'h000001, 24'hFFFFFE, 24, 24);
        finish_frame(1);
        check(n_cap - base == 2, "R7 pair count msb", 48'(n_cap - base), 48'd2);
        check_pair(base,     24'hA5A5A4, 24'h5A5A5A, "R4 R6 msb trailing bits ignored");
        check_pair(base + 1, 24'h000001, 24'hFFFFFE, "R4 R11 msb 24-bit half");
    endtask

    task automatic test_i2s;
        int base;
        start(3'b011, 2);
        base = n_cap;
        send_frame(2, 24'hC00003, 24'h3FFFFC, 24, 32);
        send_frame(2, 24'h654321, 24'h9ABCDE, 24, 25);
        finish_frame(2);
        check(n_cap - base == 2, "R7 pair count i2s", 48'(n_cap - base), 48'd2);
        check_pair(base,     24'hC00003, 24'h3FFFFC, "R5 i2s 32-bit half");
        check_pair(base + 1, 24'h654321, 24'h9ABCDE, "R5 R11 i2s 25-bit half");
    endtask

    task automatic test_orphan;
        int base;
        start(3'b011, 2);
        base = n_cap;
        send_half(1'b1, 24'hDEAD00, 24, 32, 2);
        #1;
        check(n_cap - base == 0, "R8 lone right half no strobe", 48'(n_cap - base), 48'd0);
        send_frame(2, 24'h111111, 24'h222222, 24, 32);
        finish_frame(2);
        check(n_cap - base == 1, "R8 pair count after lone half", 48'(n_cap - base), 48'd1);
        check_pair(base, 24'h111111, 24'h222222, "R8 first full frame");
    endtask

    task automatic test_hold;
        start(3'b010, 1);
        send_frame(1, 24'h0F0F0F, 24'hF0F0F0, 24, 32);
        finish_frame(1);
        for (int i = 0; i < 20; i++) begin
            @(negedge bit_clk);
            ser_data = i[0];
        end
        check({left_out, right_out} === {24'h0F0F0F, 24'hF0F0F0}, "R10 outputs hold",
              {left_out, right_out}, {24'h0F0F0F, 24'hF0F0F0});
        check(valid === 1'b0, "R10 no strobe without edge", 48'(valid), 48'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        test_reset;
        test_lsb16;
        test_lsb20;
        test_lsb24;
        test_msb;
        test_i2s;
        test_orphan;
        test_hold;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule